// File: doc/BRIEF.md
# Priority Locality Access Arbiter

This block decides which of five localities (numbered 0 to 4) owns a shared register interface at any moment. Each locality sees its own access register inside its own 4 KB address window, where the locality number is taken from address bits 14:12. Software in a locality uses this register to ask for the interface, give it up, take it by force from a lower-numbered owner, and acknowledge that it was itself displaced. The arbiter drives the current owner number on `active_loc`, or 0xFF when nobody owns the interface, and it pulses `loc_changed` for one cycle each time the owner changes.

An owned interface never changes hands directly. A release that has a waiting requester, or a seize from a higher locality, first raises `abort_req` toward the command sequencer, so that the work in progress can be stopped. The handover takes place on the clock edge where `abort_done` is seen high while `abort_req` is high. An interface that nobody owns is granted at once, with no abort.

Writes and reads are plain single-cycle strobes with no back-pressure. A write is applied on the rising edge where `wr_en` is high. `rd_data` follows `rd_addr` combinationally. Only offset 0 of each window is decoded.

Top module: `lac_arbiter`

## Requirements
- R1: After reset no locality owns the interface, `active_loc` is 0xFF, `abort_req` and `loc_changed` are low, and every locality's access register reads bit 7 = 1, bit 0 = `est_in`, and all other bits 0.
- R2: A write with bit 1 (request-use) set, made while the interface is unowned, makes that locality the owner on the same edge: `active_loc` shows its number and its bit 5 (active) reads 1.
- R3: A request-use write from a non-owner while another locality owns the interface is recorded in that locality's bit 1. Every other locality then reads bit 2 (pending) as 1. A locality's own request does not set its own bit 2.
- R4: When the owner writes bit 5, and one or more localities have request-use set, `abort_req` rises and stays high until `abort_done`. On that edge, the highest-numbered requester becomes owner with its request-use cleared. The old owner's active and request-use bits clear.
- R5: When the owner writes bit 5 and nobody is requesting, the interface becomes unowned on the same edge and `active_loc` reads 0xFF.
- R6: A non-owner writing bit 5 clears its own request-use bit.
- R7: A write with bit 3 (seize) has effect only when the writer outranks the owner or the interface is unowned. From an unowned state it grants at once. Otherwise it raises `abort_req`, and on `abort_done` the seizer becomes owner and the old owner's bit 4 (been-seized) sets.
- R8: A seize is refused when a seize is already pending for the writer or for any higher locality. An accepted seize cancels pending seizes of lower localities and redirects a pending handover to the seizer. A seize bit in the same write suppresses the bits 5 and 1 of that write.
- R9: Bit 3 always reads 0. Writing 1 to bit 4 clears the writer's been-seized flag.
- R10: Writes addressed to locality 4, to locality codes 5 to 7, or to any non-zero offset change no state. Reads of locality 4 work normally. Reads of codes 5 to 7 or of non-zero offsets return 0xFF.
- R11: `loc_changed` is high for exactly one cycle after each edge on which the owner changes, including a change to unowned. `active_loc` shows the new owner in that same cycle.
- R12: While `abort_req` is high, a further release by the owner is ignored and the owner stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 15 | Write address; bits 14:12 select the locality |
| wr_data | input | 8 | Write data for the access register |
| rd_addr | input | 15 | Read address; bits 14:12 select the locality |
| rd_data | output | 8 | Access register value for `rd_addr` (combinational) |
| est_in | input | 1 | Value shown in bit 0 of every access register |
| active_loc | output | 8 | Current owner number, 0xFF when unowned |
| loc_changed | output | 1 | One-cycle pulse after an owner change |
| abort_req | output | 1 | Abort request toward the command sequencer |
| abort_done | input | 1 | Abort completion from the command sequencer |

## Verification
The bench builds the block with its default parameters: five localities, a 15-bit address with 4 KB windows, and locality 4 as the write-protected one. With these values the unused locality codes 5 to 7 can be addressed, so out-of-range decoding is exercised. The write-protected locality is also the highest one, which lets the bench show that its request and seize writes can never take the interface. The four writable localities give enough room to stack a lower requester, a higher requester and two competing seizes against one owner. This exercises highest-requester selection, seize cancellation and retargeting within a single handover.

// File: rtl/lac_pkg.sv
package lac_pkg;
  localparam int REG_W    = 8;
  // access register bit positions (software decodes these)
  localparam int B_VALID  = 7;
  localparam int B_ACT    = 5;
  localparam int B_SEIZED = 4;
  localparam int B_SEIZE  = 3;
  localparam int B_PEND   = 2;
  localparam int B_REQ    = 1;
  localparam int B_EST    = 0;
  localparam logic [REG_W-1:0] NONE_CODE = 8'hFF;
endpackage

// File: rtl/lac_win_decode.sv
module lac_win_decode #(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 15,
  parameter int WIN_W   = 12,
  localparam int IW     = ADDR_W - WIN_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IW-1:0]     loc,
  output logic              hit
);
  assign loc = addr[ADDR_W-1:WIN_W];
  assign hit = (addr[WIN_W-1:0] == '0) && (int'(loc) < NUM_LOC);
endmodule

// File: rtl/lac_top_pick.sv
module lac_top_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lac_readback.sv
module lac_readback #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [IW-1:0] loc,
  input  logic          hit,
  input  logic          own_vld,
  input  logic [IW-1:0] own_idx,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  seized,
  input  logic          est,
  output logic [7:0]    rdata
);
  import lac_pkg::*;
  logic pend;

  always_comb begin
    pend = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (IW'(i) != loc && req[i]) pend = 1'b1;
    end
  end

  always_comb begin
    if (!hit) begin
      rdata = NONE_CODE;
    end else begin
      rdata           = '0;
      rdata[B_VALID]  = 1'b1;
      rdata[B_ACT]    = own_vld && (own_idx == loc);
      rdata[B_SEIZED] = seized[loc];
      rdata[B_SEIZE]  = 1'b0;
      rdata[B_PEND]   = pend;
      rdata[B_REQ]    = req[loc];
      rdata[B_EST]    = est;
    end
  end
endmodule

// File: rtl/lac_arbiter.sv
module lac_arbiter #(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 15,
  parameter int WIN_W   = 12,
  parameter int HW_LOC  = 4,
  localparam int IW     = ADDR_W - WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              est_in,
  output logic [7:0]        active_loc,
  output logic              loc_changed,
  output logic              abort_req,
  input  logic              abort_done
);
  import lac_pkg::*;

  // registered state
  logic               own_vld_q, abort_q, chg_q;
  logic [IW-1:0]      own_idx_q, next_q;
  logic [NUM_LOC-1:0] req_q, seize_q, seized_q;

  // after abort completion
  logic               own_vld_a, abort_a;
  logic [IW-1:0]      own_idx_a;
  logic [NUM_LOC-1:0] req_a, seize_a, seized_a;

  // after write
  logic               own_vld_d, abort_d;
  logic [IW-1:0]      own_idx_d, next_d;
  logic [NUM_LOC-1:0] req_d, seize_d, seized_d;

  logic [IW-1:0] w_loc, r_loc, pick_idx;
  logic          w_hit, r_hit, pick_any;
  logic [7:0]    wv;
  logic [NUM_LOC-1:0] above, below;

  lac_win_decode #(.NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_wdec (
    .addr(wr_addr), .loc(w_loc), .hit(w_hit));
  lac_win_decode #(.NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_rdec (
    .addr(rd_addr), .loc(r_loc), .hit(r_hit));

  lac_top_pick #(.N(NUM_LOC), .IW(IW)) u_pick (
    .vec(req_a), .any(pick_any), .idx(pick_idx));

  lac_readback #(.N(NUM_LOC), .IW(IW)) u_rb (
    .loc(r_loc), .hit(r_hit), .own_vld(own_vld_q), .own_idx(own_idx_q),
    .req(req_q), .seized(seized_q), .est(est_in), .rdata(rd_data));

  always_comb begin
    for (int i = 0; i < NUM_LOC; i++) begin
      above[i] = IW'(i) > w_loc;
      below[i] = IW'(i) < w_loc;
    end
  end

  // stage A: handover on abort completion
  always_comb begin
    own_vld_a = own_vld_q;
    own_idx_a = own_idx_q;
    req_a     = req_q;
    seize_a   = seize_q;
    seized_a  = seized_q;
    abort_a   = abort_q;
    if (abort_q && abort_done) begin
      if (seize_q[next_q]) seized_a[own_idx_q] = 1'b1;
      else                 req_a[own_idx_q]    = 1'b0;
      own_idx_a       = next_q;
      req_a[next_q]   = 1'b0;
      seize_a[next_q] = 1'b0;
      abort_a         = 1'b0;
    end
  end

  // stage B: access register write
  always_comb begin
    own_vld_d = own_vld_a;
    own_idx_d = own_idx_a;
    req_d     = req_a;
    seize_d   = seize_a;
    seized_d  = seized_a;
    abort_d   = abort_a;
    next_d    = next_q;
    wv        = wr_data;
    if (wr_en && w_hit && (w_loc != IW'(HW_LOC))) begin
      if (wv[B_SEIZE]) begin
        wv[B_ACT] = 1'b0;
        wv[B_REQ] = 1'b0;
      end
      if (wv[B_ACT]) begin
        if (own_vld_d && own_idx_d == w_loc) begin
          if (!abort_d) begin
            if (pick_any) begin
              abort_d = 1'b1;
              next_d  = pick_idx;
            end else begin
              own_vld_d = 1'b0;
            end
          end
        end else begin
          req_d[w_loc] = 1'b0;
        end
      end
      if (wv[B_SEIZED]) seized_d[w_loc] = 1'b0;
      if (wv[B_SEIZE] && (!own_vld_d || w_loc > own_idx_d) &&
          !seize_d[w_loc] && !(|(seize_d & above))) begin
        seize_d = seize_d & ~below;
        if (!own_vld_d) begin
          own_vld_d    = 1'b1;
          own_idx_d    = w_loc;
          req_d[w_loc] = 1'b0;
        end else begin
          seize_d[w_loc] = 1'b1;
          abort_d        = 1'b1;
          next_d         = w_loc;
        end
      end
      if (wv[B_REQ] && !(own_vld_d && own_idx_d == w_loc)) begin
        if (own_vld_d) begin
          req_d[w_loc] = 1'b1;
        end else begin
          own_vld_d    = 1'b1;
          own_idx_d    = w_loc;
          req_d[w_loc] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_idx_q <= '0;
      next_q    <= '0;
      abort_q   <= 1'b0;
      chg_q     <= 1'b0;
      req_q     <= '0;
      seize_q   <= '0;
      seized_q  <= '0;
    end else begin
      own_vld_q <= own_vld_d;
      own_idx_q <= own_idx_d;
      next_q    <= next_d;
      abort_q   <= abort_d;
      chg_q     <= (own_vld_d != own_vld_q) ||
                   (own_vld_d && (own_idx_d != own_idx_q));
      req_q     <= req_d;
      seize_q   <= seize_d;
      seized_q  <= seized_d;
    end
  end

  assign active_loc  = own_vld_q ? 8'(own_idx_q) : NONE_CODE;
  assign loc_changed = chg_q;
  assign abort_req   = abort_q;

  AST_CHG_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    loc_changed |-> active_loc != $past(active_loc)); // R11
  AST_ABORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req && !abort_done |=> abort_req); // R4
  AST_ABORT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> active_loc != NONE_CODE); // R4
  AST_OWNER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req && !abort_done |=> active_loc == $past(active_loc)); // R12
  AST_ONE_SEIZE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seize_q)); // R8
  AST_HW_LOC_RO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_addr[ADDR_W-1:WIN_W] == IW'(HW_LOC)) && !abort_req
    |=> req_q[HW_LOC] == $past(req_q[HW_LOC]) &&
        seized_q[HW_LOC] == $past(seized_q[HW_LOC])); // R10
endmodule

// File: tb/tb_lac_arbiter.sv
`timescale 1ns/1ps
module tb_lac_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [14:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        est_in = 1'b1;
  logic [7:0]  active_loc;
  logic        loc_changed;
  logic        abort_req;
  logic        abort_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  lac_arbiter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .est_in(est_in), .active_loc(active_loc), .loc_changed(loc_changed),
    .abort_req(abort_req), .abort_done(abort_done));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int loc, input int data, input int off = 0);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 15'((loc << 12) | off);
    wr_data = 8'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int loc, input int exp, input int off = 0);
    rd_addr = 15'((loc << 12) | off);
    #0.5;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic finish_abort();
    @(negedge clk);
    abort_done = 1'b1;
    @(negedge clk);
    abort_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 active_loc", active_loc, 8'hFF);
    check("R1 abort_req", abort_req, 0);
    check("R1 loc_changed", loc_changed, 0);
    for (int i = 0; i < 5; i++) rd_chk("R1 access", i, 8'h81);
  endtask

  task automatic t_claim_and_queue();
    wr(1, 8'h02);
    check("R2 owner", active_loc, 1);
    check("R11 pulse on grant", loc_changed, 1);
    rd_chk("R2 owner reg", 1, 8'hA1);
    @(negedge clk);
    check("R11 pulse one cycle", loc_changed, 0);
    wr(0, 8'h02);
    wr(2, 8'h02);
    check("R3 owner kept", active_loc, 1);
    check("R3 no pulse", loc_changed, 0);
    rd_chk("R3 req loc0", 0, 8'h87);
    rd_chk("R3 owner pending", 1, 8'hA5);
    rd_chk("R3 idle pending", 3, 8'h85);
    wr(0, 8'h20);
    rd_chk("R6 req cleared", 0, 8'h85);
    check("R6 owner kept", active_loc, 1);
    wr(0, 8'h02);
  endtask

  task automatic t_release_handover();
    wr(1, 8'h20);
    check("R4 abort raised", abort_req, 1);
    check("R4 owner until done", active_loc, 1);
    repeat (3) @(negedge clk);
    check("R4 abort held", abort_req, 1);
    wr(1, 8'h20);
    check("R12 owner kept", active_loc, 1);
    check("R12 abort still", abort_req, 1);
    finish_abort();
    check("R4 highest requester", active_loc, 2);
    check("R11 pulse on handover", loc_changed, 1);
    check("R4 abort dropped", abort_req, 0);
    rd_chk("R4 old owner cleared", 1, 8'h85);
    rd_chk("R4 new owner", 2, 8'hA5);
    wr(2, 8'h20);
    finish_abort();
    check("R4 next requester", active_loc, 0);
    rd_chk("R4 last owner", 0, 8'hA1);
    wr(0, 8'h20);
    check("R5 unowned", active_loc, 8'hFF);
    check("R11 pulse to unowned", loc_changed, 1);
    check("R5 no abort", abort_req, 0);
  endtask

  task automatic t_seize();
    wr(1, 8'h02);
    check("R2 regrant", active_loc, 1);
    wr(0, 8'h08);
    check("R7 lower seize refused", abort_req, 0);
    check("R7 owner kept", active_loc, 1);
    wr(2, 8'h08);
    check("R7 seize aborts", abort_req, 1);
    rd_chk("R9 seize hidden", 2, 8'h81);
    wr(3, 8'h08);
    wr(2, 8'h08);
    check("R12 owner during abort", active_loc, 1);
    finish_abort();
    check("R8 retarget to higher", active_loc, 3);
    rd_chk("R7 been seized", 1, 8'h91);
    rd_chk("R8 lower seize gone", 2, 8'h81);
    rd_chk("R7 seizer owns", 3, 8'hA1);
    wr(1, 8'h10);
    rd_chk("R9 been seized cleared", 1, 8'h81);
    wr(3, 8'h20);
    check("R5 unowned again", active_loc, 8'hFF);
    wr(2, 8'h0A);
    check("R7 unowned seize grants", active_loc, 2);
    check("R7 no abort", abort_req, 0);
    rd_chk("R8 seize masks request", 2, 8'hA1);
  endtask

  task automatic t_ignored();
    wr(4, 8'h02);
    rd_chk("R10 loc4 request ignored", 4, 8'h81);
    wr(4, 8'h08);
    check("R10 loc4 seize ignored", abort_req, 0);
    check("R10 owner kept", active_loc, 2);
    wr(1, 8'h02, 8);
    rd_chk("R10 offset write ignored", 1, 8'h81);
    wr(6, 8'h02);
    rd_chk("R10 code 6 read", 6, 8'hFF);
    rd_chk("R10 offset read", 0, 8'hFF, 4);
    rd_chk("R10 state unchanged", 0, 8'h81);
    est_in = 1'b0;
    rd_chk("R1 est bit", 0, 8'h80);
    est_in = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_claim_and_queue();
    t_release_handover();
    t_seize();
    t_ignored();
    done_flag = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule